// File: doc/BRIEF.md
# Async memory strobe timing controller

This block runs one access at a time on an 8-bit asynchronous external memory or NAND flash bus. A request names the direction, the byte to write, the cycle type (data, command or address) and a 32-bit configuration word. The block then walks the access through four timed phases: setup, strobe, hold and turnaround. Each phase lasts a programmable number of interface clock cycles. Reads and writes have their own setup, strobe and hold counts. One turnaround count follows every access.

In NAND use, a command cycle raises the command latch line and an address cycle raises the address latch line for the whole access. The device's ready/busy line can stretch the strobe phase when extended wait is enabled. The same line is also presented, registered, as bit 0 of a status output.

The configuration word and the request fields are captured when a request is accepted, so they may change during an access. Requests are accepted only while the block is idle.

Top module: `amem_strobe_ctl`

## Requirements
- R1: While reset is held, and until the first request, mem_cs_n, mem_oe_n and mem_we_n are 1, and mem_cle, mem_ale, mem_dq_oe and done are 0.
- R2: An accepted access holds setup for S+1 cycles, then strobe for T+1 cycles, then hold for H+1 cycles, then turnaround for A+1 cycles, then returns to idle. A zero field still gives one cycle. Writes take S, T and H from cfg bits [29:26], [25:20] and [19:17]. Reads take them from bits [16:13], [12:7] and [6:4]. A comes from bits [3:2]. Bits [1:0] hold the bus size, where 0 means 8 bits.
- R3: mem_we_n is 0 in exactly the strobe cycles of a write, and mem_oe_n is 0 in exactly the strobe cycles of a read. The two are never 0 together.
- R4: With cfg bit 31 clear, mem_cs_n is 0 from the first setup cycle through the last hold cycle. With bit 31 set, mem_cs_n is 0 only in the strobe cycles.
- R5: With cfg bit 30 set, every strobe cycle in which mem_ready is 0 adds one strobe cycle. With bit 30 clear, mem_ready has no effect on timing.
- R6: A command access (req_kind 1) holds mem_cle at 1 from setup through hold. An address access (req_kind 2) holds mem_ale at 1 over the same span. Data accesses (req_kind 0 or 3) raise neither line, and the two lines are never 1 together.
- R7: A write drives mem_dq_out with the accepted byte and holds mem_dq_oe at 1 from setup through hold. mem_dq_oe is 0 during reads, turnaround and idle.
- R8: A read samples mem_dq_in at the end of its last strobe cycle, including any stretched cycles, and presents that byte on rd_data.
- R9: done is 1 for exactly one cycle, which is the first turnaround cycle. In that cycle chip select and both strobes are inactive.
- R10: A request is accepted only when the block is idle. A request held through an access starts nothing until turnaround ends, and the next access then begins one cycle later. req_write, req_kind, req_wdata and cfg_word are used only as sampled at acceptance.
- R11: status bit 0 equals mem_ready delayed by one clock cycle, and the other status bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Access request, taken when the block is idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_kind | input | 2 | 0 data, 1 command, 2 address, 3 data |
| req_wdata | input | 8 | Byte to write |
| cfg_word | input | 32 | Timing and option word |
| mem_ready | input | 1 | Device ready (1) or busy (0), synchronous to clk |
| mem_dq_in | input | 8 | Data bus as seen from the pads |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable (read strobe), active low |
| mem_we_n | output | 1 | Write enable (write strobe), active low |
| mem_cle | output | 1 | Command latch line |
| mem_ale | output | 1 | Address latch line |
| mem_dq_out | output | 8 | Data bus value to drive |
| mem_dq_oe | output | 1 | Data bus driver enable |
| rd_data | output | 8 | Last byte read |
| done | output | 1 | One-cycle completion pulse |
| status | output | 8 | Bit 0 registered ready, other bits 0 |

## Verification
Extended wait and the end of the strobe phase can fall in the same cycle. If the device reports busy in what would otherwise be the last strobe cycle, the block must hold off both leaving strobe and capturing read data. The bench provokes this by driving mem_ready low for one to three cycles, starting at the first strobe cycle, while the bus value changes every cycle. It judges the result by three things: the strobe length must be T+1 plus the busy count, rd_data must hold the byte present in the true last strobe cycle, and every other pin must shift by the same number of cycles. The same stimulus with extended wait disabled must leave the timing untouched.

// File: rtl/amem_pkg.sv
package amem_pkg;

  localparam int CFG_W      = 32;
  localparam int CNT_W      = 6;

  localparam int SELSTB_BIT = 31;
  localparam int EXTW_BIT   = 30;

  localparam int SU_W = 4;
  localparam int ST_W = 6;
  localparam int HD_W = 3;
  localparam int TA_W = 2;

  localparam int WSU_LSB = 26;
  localparam int WST_LSB = 20;
  localparam int WHD_LSB = 17;
  localparam int RSU_LSB = 13;
  localparam int RST_LSB = 7;
  localparam int RHD_LSB = 4;
  localparam int TA_LSB  = 2;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_RSVD = 2'd3
  } kind_e;

  typedef struct packed {
    logic             sel_strobe;
    logic             ext_wait;
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] strobe;
    logic [CNT_W-1:0] hold;
    logic [CNT_W-1:0] turn;
  } timing_t;

endpackage

// File: rtl/amem_cfg_decode.sv
module amem_cfg_decode
  import amem_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  input  logic             is_write,
  output timing_t          tm
);

  logic unused_bus_size;
  assign unused_bus_size = ^cfg[TA_LSB-1:0];

  always_comb begin
    tm.sel_strobe = cfg[SELSTB_BIT];
    tm.ext_wait   = cfg[EXTW_BIT];
    tm.turn       = {{(CNT_W-TA_W){1'b0}}, cfg[TA_LSB +: TA_W]};
    if (is_write) begin
      tm.setup  = {{(CNT_W-SU_W){1'b0}}, cfg[WSU_LSB +: SU_W]};
      tm.strobe = {{(CNT_W-ST_W){1'b0}}, cfg[WST_LSB +: ST_W]};
      tm.hold   = {{(CNT_W-HD_W){1'b0}}, cfg[WHD_LSB +: HD_W]};
    end else begin
      tm.setup  = {{(CNT_W-SU_W){1'b0}}, cfg[RSU_LSB +: SU_W]};
      tm.strobe = {{(CNT_W-ST_W){1'b0}}, cfg[RST_LSB +: ST_W]};
      tm.hold   = {{(CNT_W-HD_W){1'b0}}, cfg[RHD_LSB +: HD_W]};
    end
  end

endmodule

// File: rtl/amem_phase_fsm.sv
module amem_phase_fsm
  import amem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] setup_live,
  input  logic [CNT_W-1:0] strobe_run,
  input  logic [CNT_W-1:0] hold_run,
  input  logic [CNT_W-1:0] turn_run,
  input  logic             ext_wait_run,
  input  logic             ready,
  output phase_e           phase,
  output logic             strobe_end,
  output logic             hold_end
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  phase_e           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;
  logic             stall;

  assign cnt_zero = (cnt_q == '0);
  assign stall    = (phase_q == PH_STROBE) && ext_wait_run && !ready;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = setup_live;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_STROBE;
          cnt_d   = strobe_run;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      PH_STROBE: begin
        if (!stall) begin
          if (cnt_zero) begin
            phase_d = PH_HOLD;
            cnt_d   = hold_run;
          end else begin
            cnt_d = cnt_q - CNT_ONE;
          end
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          phase_d = PH_TURN;
          cnt_d   = turn_run;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      PH_TURN: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - CNT_ONE;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase      = phase_q;
  assign strobe_end = (phase_q == PH_STROBE) && cnt_zero && !stall;
  assign hold_end   = (phase_q == PH_HOLD) && cnt_zero;

endmodule

// File: rtl/amem_pin_decode.sv
module amem_pin_decode
  import amem_pkg::*;
(
  input  phase_e      phase,
  input  logic        is_write,
  input  logic [1:0]  kind,
  input  logic        sel_strobe,
  output logic        cs_n,
  output logic        oe_n,
  output logic        we_n,
  output logic        cle,
  output logic        ale,
  output logic        dq_oe
);

  logic in_access;
  logic in_strobe;

  assign in_access = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
  assign in_strobe = (phase == PH_STROBE);

  always_comb begin
    cs_n  = sel_strobe ? !in_strobe : !in_access;
    oe_n  = !(in_strobe && !is_write);
    we_n  = !(in_strobe && is_write);
    cle   = in_access && (kind == KIND_CMD);
    ale   = in_access && (kind == KIND_ADDR);
    dq_oe = in_access && is_write;
  end

endmodule

// File: rtl/amem_datapath.sv
module amem_datapath #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] dq_in,
  input  logic          hold_end,
  input  logic          ready,
  output logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          done,
  output logic [DW-1:0] status
);

  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;
  logic [DW-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (accept) begin
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (capture) begin
      rdata_q <= dq_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q   <= 1'b0;
      status_q <= '0;
    end else begin
      done_q   <= hold_end;
      status_q <= {{(DW-1){1'b0}}, ready};
    end
  end

  assign wdata  = wdata_q;
  assign rdata  = rdata_q;
  assign done   = done_q;
  assign status = status_q;

endmodule

// File: rtl/amem_strobe_ctl.sv
module amem_strobe_ctl
  import amem_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_kind,
  input  logic [DW-1:0]    req_wdata,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic             mem_ready,
  input  logic [DW-1:0]    mem_dq_in,
  output logic             mem_cs_n,
  output logic             mem_oe_n,
  output logic             mem_we_n,
  output logic             mem_cle,
  output logic             mem_ale,
  output logic [DW-1:0]    mem_dq_out,
  output logic             mem_dq_oe,
  output logic [DW-1:0]    rd_data,
  output logic             done,
  output logic [DW-1:0]    status
);

  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe[RST_STAGES-1];

  phase_e     phase;
  logic       accept;
  logic       strobe_end;
  logic       hold_end;
  timing_t    tm_live;
  timing_t    tm_q;
  logic       wr_q;
  logic [1:0] kind_q;

  assign accept = req_valid && (phase == PH_IDLE);

  amem_cfg_decode u_dec (
    .cfg      (cfg_word),
    .is_write (req_write),
    .tm       (tm_live)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tm_q   <= '0;
      wr_q   <= 1'b0;
      kind_q <= KIND_DATA;
    end else if (accept) begin
      tm_q   <= tm_live;
      wr_q   <= req_write;
      kind_q <= req_kind;
    end
  end

  amem_phase_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .start        (accept),
    .setup_live   (tm_live.setup),
    .strobe_run   (tm_q.strobe),
    .hold_run     (tm_q.hold),
    .turn_run     (tm_q.turn),
    .ext_wait_run (tm_q.ext_wait),
    .ready        (mem_ready),
    .phase        (phase),
    .strobe_end   (strobe_end),
    .hold_end     (hold_end)
  );

  logic unused_tm;
  assign unused_tm = ^tm_q.setup;

  amem_pin_decode u_pins (
    .phase      (phase),
    .is_write   (wr_q),
    .kind       (kind_q),
    .sel_strobe (tm_q.sel_strobe),
    .cs_n       (mem_cs_n),
    .oe_n       (mem_oe_n),
    .we_n       (mem_we_n),
    .cle        (mem_cle),
    .ale        (mem_ale),
    .dq_oe      (mem_dq_oe)
  );

  amem_datapath #(.DW(DW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .accept    (accept),
    .req_wdata (req_wdata),
    .capture   (strobe_end && !wr_q),
    .dq_in     (mem_dq_in),
    .hold_end  (hold_end),
    .ready     (mem_ready),
    .wdata     (mem_dq_out),
    .rdata     (rd_data),
    .done      (done),
    .status    (status)
  );

endmodule

// File: rtl/amem_strobe_chk.sv
module amem_strobe_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_cs_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_cle,
  input logic          mem_ale,
  input logic [DW-1:0] mem_dq_out,
  input logic          mem_dq_oe,
  input logic          done
);

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);

  p_latch_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_cle && mem_ale));

  p_no_drive_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_wdata_steady_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

bind amem_strobe_ctl amem_strobe_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_cs_n   (mem_cs_n),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .mem_cle    (mem_cle),
  .mem_ale    (mem_ale),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe),
  .done       (done)
);

// File: tb/sim_amem_strobe_ctl.sv
module sim_amem_strobe_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_write;
  logic [1:0]    req_kind;
  logic [DW-1:0] req_wdata;
  logic [31:0]   cfg_word;
  logic          mem_ready;
  logic [DW-1:0] mem_dq_in;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_cle, mem_ale, mem_dq_oe, done;
  logic [DW-1:0] mem_dq_out, rd_data, status;

  int n_tests = 0;
  int n_fail  = 0;

  amem_strobe_ctl #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_kind(req_kind), .req_wdata(req_wdata), .cfg_word(cfg_word),
    .mem_ready(mem_ready), .mem_dq_in(mem_dq_in), .mem_cs_n(mem_cs_n),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_cle(mem_cle), .mem_ale(mem_ale),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .rd_data(rd_data),
    .done(done), .status(status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input bit sel, input bit ew,
      input int ws, input int wt, input int wh,
      input int rs, input int rt, input int rh, input int ta);
    logic [31:0] c;
    c = '0;
    c[31]    = sel;
    c[30]    = ew;
    c[29:26] = 4'(ws);
    c[25:20] = 6'(wt);
    c[19:17] = 3'(wh);
    c[16:13] = 4'(rs);
    c[12:7]  = 6'(rt);
    c[6:4]   = 3'(rh);
    c[3:2]   = 2'(ta);
    return c;
  endfunction

  function automatic logic [7:0] bus_val(input int i);
    return 8'(8'h5A + i * 7);
  endfunction

  // One access; kdrv = number of busy cycles driven from the first strobe cycle.
  task automatic do_access(input bit wr, input logic [1:0] kind, input logic [7:0] wd,
                           input logic [31:0] cfg, input int kdrv, input string tag);
    int s, t, h, a, k, act_end, st_lo, st_hi, total, n_strobe;
    int m_cs, m_we, m_oe, m_cle, m_ale, m_dqoe, m_dqv, m_done;
    bit sel, ew, active, strobe;
    s = wr ? int'(cfg[29:26]) : int'(cfg[16:13]);
    t = wr ? int'(cfg[25:20]) : int'(cfg[12:7]);
    h = wr ? int'(cfg[19:17]) : int'(cfg[6:4]);
    a = int'(cfg[3:2]);
    sel = cfg[31];
    ew  = cfg[30];
    k = ew ? kdrv : 0;
    st_lo   = s + 1;
    st_hi   = s + 1 + t + k;
    act_end = s + t + h + 3 + k;
    total   = act_end + a + 1;
    m_cs = 0; m_we = 0; m_oe = 0; m_cle = 0; m_ale = 0;
    m_dqoe = 0; m_dqv = 0; m_done = 0; n_strobe = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_kind = kind; req_wdata = wd; cfg_word = cfg;
    @(negedge clk);
    // R10: inputs scrambled after acceptance must not matter
    req_valid = 1'b0; req_write = ~wr; req_kind = ~kind; req_wdata = ~wd; cfg_word = ~cfg;
    for (int idx = 0; idx <= total; idx++) begin
      if (idx > 0) @(negedge clk);
      mem_dq_in = bus_val(idx);
      mem_ready = !(idx >= st_lo && idx < st_lo + kdrv);
      active = (idx < act_end);
      strobe = (idx >= st_lo) && (idx <= st_hi);
      if (!mem_oe_n || !mem_we_n) n_strobe++;
      if (mem_cs_n !== !(sel ? strobe : active)) m_cs++;
      if (mem_we_n !== !(strobe && wr)) m_we++;
      if (mem_oe_n !== !(strobe && !wr)) m_oe++;
      if (mem_cle !== (active && kind == 2'd1)) m_cle++;
      if (mem_ale !== (active && kind == 2'd2)) m_ale++;
      if (mem_dq_oe !== (active && wr)) m_dqoe++;
      if (active && wr && mem_dq_out !== wd) m_dqv++;
      if (done !== (idx == act_end)) m_done++;
    end
    mem_ready = 1'b1;
    chk(m_cs == 0,   {tag, " R4 chip select mismatched cycles"}, m_cs, 0);
    chk(m_we == 0,   {tag, " R3 write strobe mismatched cycles"}, m_we, 0);
    chk(m_oe == 0,   {tag, " R3 read strobe mismatched cycles"}, m_oe, 0);
    chk(m_cle == 0 && m_ale == 0, {tag, " R6 latch line mismatched cycles"}, m_cle + m_ale, 0);
    chk(m_dqoe == 0, {tag, " R7 bus enable mismatched cycles"}, m_dqoe, 0);
    chk(m_dqv == 0,  {tag, " R7/R10 write byte mismatched cycles"}, m_dqv, 0);
    chk(m_done == 0, {tag, " R9 done mismatched cycles"}, m_done, 0);
    chk(n_strobe == t + 1 + k, {tag, ew ? " R5 strobe length" : " R2 strobe length"},
        n_strobe, t + 1 + k);
    if (!wr)
      chk(rd_data == bus_val(st_hi), {tag, " R8 captured byte"}, int'(rd_data), int'(bus_val(st_hi)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog (R2 run did not complete): got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_kind = 2'd0;
    req_wdata = '0; cfg_word = '0; mem_ready = 1'b1; mem_dq_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_cs_n && mem_oe_n && mem_we_n, "R1 strobes idle in reset", 0, 1);
    chk(!mem_cle && !mem_ale && !mem_dq_oe && !done, "R1 lines low in reset", 1, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !done, "R1 idle after reset", 0, 1);

    // R11 status follows ready one cycle later
    mem_ready = 1'b0;
    @(negedge clk);
    chk(status == 8'h00, "R11 status busy", int'(status), 0);
    mem_ready = 1'b1;
    @(negedge clk);
    chk(status == 8'h01, "R11 status ready", int'(status), 1);

    // R2/R3/R4/R6/R7/R8/R9 sweep over phase lengths, direction, select mode and kind
    n = 0;
    for (int s = 0; s <= 2; s += 2)
      for (int t = 0; t <= 3; t += 3)
        for (int h = 0; h <= 1; h++)
          for (int a = 0; a <= 3; a++)
            for (int wr = 0; wr <= 1; wr++)
              for (int sel = 0; sel <= 1; sel++) begin
                do_access(wr[0], 2'(n), 8'(8'h31 + n * 13),
                          mk_cfg(sel[0], 1'b0, s, t, h, s ^ 1, t ^ 1, h ^ 1, a),
                          0, "sweep");
                n++;
              end

    // R2 widest fields
    do_access(1'b1, 2'd1, 8'hC3, mk_cfg(1'b0, 1'b0, 15, 63, 7, 0, 0, 0, 3), 0, "max write");
    do_access(1'b0, 2'd2, 8'h00, mk_cfg(1'b0, 1'b0, 0, 0, 0, 15, 63, 7, 3), 0, "max read");

    // R5 extended wait colliding with the strobe end, and R5 ignored when disabled
    for (int ew = 0; ew <= 1; ew++)
      for (int wr = 0; wr <= 1; wr++)
        for (int k = 1; k <= 3; k++)
          do_access(wr[0], 2'd0, 8'(8'hA0 + k), mk_cfg(1'b0, ew[0], 1, 0, 1, 1, 0, 1, 1), k,
                    ew ? "ext wait" : "wait off");

    // R10 back-to-back with request held: gap of A+2 cycles with chip select high
    for (int a = 0; a <= 3; a++) begin
      int i_rise, i_fall, s, t, h;
      bit prev;
      s = 1; t = 2; h = 1;
      i_rise = -1; i_fall = -1;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_kind = 2'd0; req_wdata = 8'h77;
      cfg_word = mk_cfg(1'b0, 1'b0, s, t, h, 0, 0, 0, a);
      @(negedge clk);
      prev = mem_cs_n;
      for (int idx = 1; idx < 60; idx++) begin
        @(negedge clk);
        if (!prev && mem_cs_n && i_rise < 0) i_rise = idx;
        if (prev && !mem_cs_n && i_rise >= 0 && i_fall < 0) begin
          i_fall = idx;
          req_valid = 1'b0;
        end
        prev = mem_cs_n;
      end
      req_valid = 1'b0;
      chk(i_rise == s + t + h + 3, "R10 held request starts nothing mid-access", i_rise, s + t + h + 3);
      chk(i_fall - i_rise == a + 2, "R10 restart gap after turnaround", i_fall - i_rise, a + 2);
    end

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule